// File: doc/BRIEF.md
# SPI Clock Divider with Phase-Controlled Strobes

This block derives the serial clock of an SPI controller from the fast input clock. It also produces the timing strobes that a separate data shifter uses. An 8-bit divider sets the SCLK period in input-clock cycles, and the value zero selects the longest period of 256 cycles. A 3-bit signalling field sets the idle level of SCLK and, independently for the transmit and receive sides, whether data moves on the leading or the trailing SCLK edge. Because the two sides are set independently, the controller can sample and launch on the same edge when it runs at full speed (divide-by-1).

A sequencer raises `run_i` for as long as it wants clocks. The block first spends one preparation cycle with SCLK idle, so a leading-edge-sampling transfer can present its first bit. It then toggles SCLK and pulses `launch_o`, `sample_o` and `bit_end_o` in the input-clock cycle that follows each relevant SCLK edge. The divider and signalling settings are captured when the block leaves idle and stay fixed until it returns there. A package function converts a standard SPI mode number into the 3-bit field, with one table for divide-by-1 and one for all other dividers.

Top module: `spi_clk_gen`

## Requirements
- R1: While reset is held and after it is released with run low, sclk_o is 0 and launch_o, sample_o and bit_end_o are 0.
- R2: When enable and run are both high in idle, the next cycle is a preparation cycle: sclk_o stays at idle level, sample_o and bit_end_o are 0, and launch_o is 1 exactly when the output-phase bit (field bit 1) is 0.
- R3: For a divider value D of 2 to 255, or 0 meaning N=256 (otherwise N=D), SCLK has a period of N input cycles. Counting run cycles from k=0 after the preparation cycle, SCLK is at the active level (not CPOL) when (k mod N) < floor(N/2), and at the CPOL level otherwise.
- R4: With divider 1, during run cycles sclk_o equals CPOL inverted while the input clock is high and equals CPOL while it is low; in the preparation cycle it stays at CPOL.
- R5: launch_o pulses in run cycles where (k mod N) is 0 if the output-phase bit is 1, and where (k mod N) equals floor(N/2) if it is 0. At divider 1 it pulses every run cycle.
- R6: sample_o pulses in run cycles where (k mod N) equals floor(N/2) if the input-phase bit (field bit 2) is 1, and where (k mod N) is 0 if it is 0.
- R7: bit_end_o pulses in the run cycles where (k mod N) equals N-1.
- R8: The field bit 0 (CPOL) sets the idle level of SCLK, which follows the input one cycle after a change in idle. Divider and field are captured when leaving idle, and changes to them during a transfer have no effect.
- R9: Lowering run or enable forces all three strobes low at once, and sclk_o returns to the CPOL level from the next clock edge. With enable low, run has no effect.
- R10: The mode-to-field function returns 0x0, 0x6, 0x1, 0x7 for SPI modes 0 to 3 when not at divide-by-1, and 0x4, 0x2, 0x5, 0x3 at divide-by-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock that SCLK is derived from |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable |
| run_i | input | 1 | Run request from the sequencer |
| div_i | input | 8 | Divider value, 0 selects 256 |
| mode_i | input | 3 | Signalling field: bit0 CPOL, bit1 output phase, bit2 input phase |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | Transmit-change strobe |
| sample_o | output | 1 | Receive-sample strobe |
| bit_end_o | output | 1 | Last input cycle of each SCLK period |

## Verification
If the phase counter is wrong, the SCLK level and the strobe pattern drift away from the expected position within a single SCLK period. The bench checks every output in every cycle of two full periods, so such a drift is caught within at most N cycles. If the captured settings are wrong, the bench sees it in the first run cycle: every transfer changes the divider and field inputs right after they are captured. A gate or state machine that does not return to idle shows up one edge after run drops, as SCLK off its idle level or as a stray strobe.

// File: rtl/spi_clk_pkg.sv
package spi_clk_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_RUN} clk_st_e;

  // bit0 cpol, bit1 output phase, bit2 input phase
  typedef struct packed {
    logic cpha_in;
    logic cpha_out;
    logic cpol;
  } sig_mode_t;

  function automatic logic [2:0] mode_code(input logic [1:0] spi_mode, input logic full_speed);
    logic [2:0] code;
    unique case ({full_speed, spi_mode})
      3'b000: code = 3'h0;
      3'b001: code = 3'h6;
      3'b010: code = 3'h1;
      3'b011: code = 3'h7;
      3'b100: code = 3'h4;
      3'b101: code = 3'h2;
      3'b110: code = 3'h5;
      default: code = 3'h3;
    endcase
    return code;
  endfunction
endpackage

// File: rtl/spi_clk_cnt.sv
module spi_clk_cnt #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          adv_i,
  input  logic [CW-1:0] n_i,
  output logic [CW-1:0] cnt_o,
  output logic          act_o
);
  logic [CW-1:0] half, last, nxt;

  assign half = n_i >> 1;
  assign last = n_i - CW'(1);
  assign nxt  = (cnt_o == last) ? '0 : cnt_o + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      act_o <= 1'b0;
    end else if (start_i) begin
      cnt_o <= '0;
      act_o <= (half != '0);
    end else if (adv_i) begin
      cnt_o <= nxt;
      act_o <= (nxt < half);
    end else begin
      cnt_o <= '0;
      act_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_clk_strobe.sv
module spi_clk_strobe #(
  parameter int CW = 9
) (
  input  logic          active_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] n_i,
  input  logic          cpha_out_i,
  input  logic          cpha_in_i,
  output logic          launch_o,
  output logic          sample_o,
  output logic          bit_end_o
);
  logic lead, trail;

  assign lead      = active_i && (cnt_i == '0);
  assign trail     = active_i && (cnt_i == (n_i >> 1));
  assign launch_o  = cpha_out_i ? lead : trail;
  assign sample_o  = cpha_in_i ? trail : lead;
  assign bit_end_o = active_i && (cnt_i == n_i - CW'(1));
endmodule

// File: rtl/spi_clk_gate.sv
module spi_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);
  logic gate_q;

  // enable changes only while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= en_i;
  end

  assign gclk_o = clk_i & gate_q;
endmodule

// File: rtl/spi_clk_gen.sv
module spi_clk_gen
  import spi_clk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [2:0]       mode_i,
  output logic             sclk_o,
  output logic             launch_o,
  output logic             sample_o,
  output logic             bit_end_o
);
  localparam int CW = DIV_W + 1;
  localparam logic [CW-1:0] N_MAX = CW'(1) << DIV_W;

  clk_st_e          state_q;
  logic [DIV_W-1:0] div_q;
  sig_mode_t        mode_q;
  logic             go, start, adv, div1, gclk, act;
  logic             run_launch, prep_launch;
  logic [CW-1:0]    n, cnt;

  assign go    = en_i & run_i;
  assign start = (state_q == ST_PREP) && go;
  assign adv   = (state_q == ST_RUN) && go;
  assign n     = (div_q == '0) ? N_MAX : {1'b0, div_q};
  assign div1  = (div_q == DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      mode_q  <= '0;
    end else begin
      if (state_q == ST_IDLE) begin
        div_q  <= div_i;
        mode_q <= sig_mode_t'(mode_i);
      end
      unique case (state_q)
        ST_IDLE: state_q <= go ? ST_PREP : ST_IDLE;
        ST_PREP: state_q <= go ? ST_RUN : ST_IDLE;
        default: state_q <= go ? ST_RUN : ST_IDLE;
      endcase
    end
  end

  spi_clk_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .adv_i  (adv),
    .n_i    (n),
    .cnt_o  (cnt),
    .act_o  (act)
  );

  spi_clk_gate u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (div1 && go && (state_q != ST_IDLE)),
    .gclk_o(gclk)
  );

  spi_clk_strobe #(.CW(CW)) u_strobe (
    .active_i  (adv),
    .cnt_i     (cnt),
    .n_i       (n),
    .cpha_out_i(mode_q.cpha_out),
    .cpha_in_i (mode_q.cpha_in),
    .launch_o  (run_launch),
    .sample_o  (sample_o),
    .bit_end_o (bit_end_o)
  );

  // leading-edge sampling needs the first bit out before the first edge
  assign prep_launch = start && !mode_q.cpha_out;
  assign launch_o    = run_launch | prep_launch;
  assign sclk_o      = mode_q.cpol ^ (div1 ? gclk : act);

  a_r2_prep_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PREP) |-> (!sample_o && !bit_end_o));

  a_r3_lead_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !div1 && cnt == '0) |-> act);

  a_r7_bit_end_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |=> (cnt == '0));

  a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ($stable(div_q) && $stable(mode_q)));

  a_r8_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !div1) |-> (sclk_o == mode_q.cpol));

  a_r9_stop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go |-> (!launch_o && !sample_o && !bit_end_o));
endmodule

// File: tb/tb_spi_clk_gen.sv
module tb_spi_clk_gen;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic       run_i = 1'b0;
  logic [7:0] div_i = 8'd2;
  logic [2:0] mode_i = 3'd0;
  logic       sclk_o, launch_o, sample_o, bit_end_o;

  int total = 0;
  int fails = 0;
  bit done = 0;

  spi_clk_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .run_i(run_i),
    .div_i(div_i), .mode_i(mode_i), .sclk_o(sclk_o),
    .launch_o(launch_o), .sample_o(sample_o), .bit_end_o(bit_end_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // one transfer of two full periods plus one cycle, then stop
  task automatic run_cfg(input int dv, input int md);
    int n, h, cpol, co, ci, cnt, act;
    n = (dv == 0) ? 256 : dv;
    h = n / 2;
    cpol = md & 1;
    co = (md >> 1) & 1;
    ci = (md >> 2) & 1;
    div_i = 8'(dv);
    mode_i = 3'(md);
    @(posedge clk_i); @(posedge clk_i); #2;
    chk("R8 idle level", int'(sclk_o), cpol);
    chk("R9 idle launch", int'(launch_o), 0);
    #1 run_i = 1'b1;
    @(posedge clk_i); #2;
    chk("R2 prep sclk", int'(sclk_o), cpol);
    chk("R2 prep launch", int'(launch_o), 1 - co);
    chk("R2 prep sample", int'(sample_o), 0);
    chk("R2 prep bit_end", int'(bit_end_o), 0);
    #5;
    chk("R4 prep sclk low phase", int'(sclk_o), cpol);
    #1;
    mode_i = ~3'(md);
    div_i = 8'(dv + 3);
    for (int k = 0; k < 2 * n + 1; k++) begin
      cnt = k % n;
      act = (n == 1) ? 1 : int'(cnt < h);
      @(posedge clk_i); #2;
      chk((n == 1) ? "R4 sclk high phase" : "R3 sclk", int'(sclk_o), cpol ^ act);
      chk("R5 launch", int'(launch_o), co ? int'(cnt == 0) : int'(cnt == h));
      chk("R6 sample", int'(sample_o), ci ? int'(cnt == h) : int'(cnt == 0));
      chk("R7 bit_end", int'(bit_end_o), int'(cnt == n - 1));
      #5;
      chk((n == 1) ? "R4 sclk low phase" : "R3 sclk steady", int'(sclk_o),
          (n == 1) ? cpol : (cpol ^ act));
    end
    @(posedge clk_i); #3;
    run_i = 1'b0;
    #1;
    chk("R9 launch off", int'(launch_o), 0);
    chk("R9 sample off", int'(sample_o), 0);
    chk("R9 bit_end off", int'(bit_end_o), 0);
    @(posedge clk_i); #2;
    chk("R9 sclk back to idle", int'(sclk_o), cpol);
    #5;
    chk("R9 sclk idle low phase", int'(sclk_o), cpol);
    mode_i = 3'(md);
    div_i = 8'(dv);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      summary();
    end
  end

  initial begin
    int dv_set[7] = '{1, 2, 3, 4, 5, 8, 0};
    #3;
    chk("R1 sclk in reset", int'(sclk_o), 0);
    chk("R1 launch in reset", int'(launch_o), 0);
    #(CLK_P * 2) rst_ni = 1'b1;
    @(posedge clk_i); #2;
    chk("R1 sclk after reset", int'(sclk_o), 0);
    chk("R1 sample after reset", int'(sample_o), 0);
    chk("R1 bit_end after reset", int'(bit_end_o), 0);

    for (int m = 0; m < 4; m++) begin
      chk("R10 std table", int'(spi_clk_pkg::mode_code(2'(m), 1'b0)),
          (m == 0) ? 0 : (m == 1) ? 6 : (m == 2) ? 1 : 7);
      chk("R10 full-speed table", int'(spi_clk_pkg::mode_code(2'(m), 1'b1)),
          (m == 0) ? 4 : (m == 1) ? 2 : (m == 2) ? 5 : 3);
    end

    foreach (dv_set[i]) begin
      for (int md = 0; md < 8; md++) run_cfg(dv_set[i], md);
    end

    // enable low: run has no effect
    div_i = 8'd2;
    mode_i = 3'd1;
    en_i = 1'b0;
    @(posedge clk_i); #3;
    run_i = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(posedge clk_i); #2;
      chk("R9 disabled sclk", int'(sclk_o), 1);
      chk("R9 disabled launch", int'(launch_o), 0);
      chk("R9 disabled sample", int'(sample_o), 0);
    end
    #1 en_i = 1'b1;
    @(posedge clk_i); #2;
    chk("R2 prep after enable", int'(sclk_o), 1);
    @(posedge clk_i); #2;
    chk("R3 first edge after enable", int'(sclk_o), 0);
    #1 run_i = 1'b0;
    @(posedge clk_i); #2;
    chk("R9 idle after enable test", int'(sclk_o), 1);

    done = 1;
    summary();
  end
endmodule